// File: doc/BRIEF.md
# Convolution Tile Loop Scheduler

This block drives one convolution layer through three nested loops. The outer loop walks the spatial tiles of the output map in row-major order, with the column index moving fastest. The middle loop walks the groups of output kernels. The inner loop walks the slices of input channels. For every channel slice it issues three commands in turn: fetch the input window, fetch the weight slice, then run the compute engine on that pair. After the last slice of a group it issues one store command, so the group's finished partial sums go out before the next group begins.

Each command carries everything a memory controller or datapath needs for that step:

- the tile and loop indices,
- the tile origin in map coordinates,
- the origin of the input window, which is one row and one column above and to the left of the tile so the 3x3 kernel has its halo,
- edge flags marking the window sides that fall outside the map and must be filled with zeros,
- a flat weight-slice index,
- first and last markers, which tell the compute engine when to start a fresh accumulation and when to finalize it.

A one-cycle start launches the layer. Commands leave on a valid/ready stream, and a one-cycle done pulse marks the end.

Top module: `tile_sched_top`

## Requirements
- R1: While reset is high and after it is released, cmd_valid and done are 0 until a start is seen.
- R2: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and every command field stays unchanged in the next cycle.
- R3: Commands follow this order:
  - tile row, then tile column (column fastest) outermost;
  - kernel group next;
  - channel slice innermost, ascending;
  - for each slice, the op sequence load-input, load-weight, compute.
- R4: cmd_first is 1 exactly when the slice index is 0, and cmd_last is 1 exactly when it is N_SLICES-1.
- R5: Exactly one store command follows the compute of the last slice of each group. It carries that group's tile and group indices, with the slice index N_SLICES-1.
- R6: One cycle after the last tile's last store is accepted, done is 1 for exactly one cycle and cmd_valid is 0.
- R7: cmd_org_r equals tile_r*TILE_H and cmd_org_c equals tile_c*TILE_W. cmd_win_r and cmd_win_c equal those origins minus 1, in two's complement.
- R8: cmd_pad bit 3 is set for the top tile row and bit 2 for the bottom tile row. Bit 1 is set for the left tile column and bit 0 for the right tile column.
- R9: A start while a layer is in progress has no effect on the command sequence. A start after done runs the whole layer again from tile 0.
- R10: cmd_wt_idx equals group*N_SLICES + slice.
- R11: cmd_op codes are 0 load-input, 1 load-weight, 2 compute and 3 store.
- R12: One layer issues exactly (IMG_H/TILE_H)*(IMG_W/TILE_W)*N_GROUPS*(3*N_SLICES+1) commands before done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a layer (ignored while running) |
| done | output | 1 | One-cycle pulse after the final store is accepted |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_op | output | 2 | Operation code (R11) |
| cmd_tile_r | output | TRW | Tile row index |
| cmd_tile_c | output | TCW | Tile column index |
| cmd_grp | output | GW | Kernel group index |
| cmd_slc | output | SW | Channel slice index |
| cmd_org_r | output | RW | Tile origin row |
| cmd_org_c | output | CW | Tile origin column |
| cmd_win_r | output | RW | Input window origin row (signed) |
| cmd_win_c | output | CW | Input window origin column (signed) |
| cmd_pad | output | 4 | Zero-fill sides {top,bottom,left,right} |
| cmd_first | output | 1 | First slice of the group |
| cmd_last | output | 1 | Last slice of the group |
| cmd_wt_idx | output | WIW | Flat weight-slice index |

## Verification
Any wrong loop counter shows up in the very next accepted command. A counter that wraps early or late produces a tuple that breaks the expected nested order, and it also disagrees with the derived origin, pad and weight-index fields. A phase error shows as a missing or misplaced store, or as misplaced first and last flags, within one slice of the fault. An end-of-layer error shows as done arriving before or after the exact command count. Stalling cmd_ready with several patterns exposes any field that moves while the consumer is not accepting.

// File: rtl/tile_sched_pkg.sv
package tile_sched_pkg;
  typedef enum logic [1:0] {
    OP_LD_IN   = 2'd0,
    OP_LD_WT   = 2'd1,
    OP_COMPUTE = 2'd2,
    OP_STORE   = 2'd3
  } op_e;

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tile_sched_step.sv
module tile_sched_step
  import tile_sched_pkg::*;
#(
  parameter int TROWS = 2,
  parameter int TCOLS = 3,
  parameter int NGRP  = 2,
  parameter int NSLC  = 3,
  localparam int TRW = idx_w(TROWS),
  localparam int TCW = idx_w(TCOLS),
  localparam int GW  = idx_w(NGRP),
  localparam int SW  = idx_w(NSLC)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           adv,
  output logic [TRW-1:0] nxt_tr,
  output logic [TCW-1:0] nxt_tc,
  output logic [GW-1:0]  nxt_g,
  output logic [SW-1:0]  nxt_s,
  output op_e            nxt_ph,
  output logic           at_end
);
  logic [TRW-1:0] tr;
  logic [TCW-1:0] tc;
  logic [GW-1:0]  g;
  logic [SW-1:0]  s;
  op_e            ph;

  logic lst_s, lst_g, lst_c, lst_r;
  assign lst_s = (s  == SW'(NSLC - 1));
  assign lst_g = (g  == GW'(NGRP - 1));
  assign lst_c = (tc == TCW'(TCOLS - 1));
  assign lst_r = (tr == TRW'(TROWS - 1));
  assign at_end = (ph == OP_STORE) && lst_g && lst_c && lst_r;

  always_comb begin
    nxt_tr = tr;
    nxt_tc = tc;
    nxt_g  = g;
    nxt_s  = s;
    nxt_ph = ph;
    unique case (ph)
      OP_LD_IN: nxt_ph = OP_LD_WT;
      OP_LD_WT: nxt_ph = OP_COMPUTE;
      OP_COMPUTE: begin
        if (lst_s) begin
          nxt_ph = OP_STORE;
        end else begin
          nxt_ph = OP_LD_IN;
          nxt_s  = s + SW'(1);
        end
      end
      default: begin
        nxt_ph = OP_LD_IN;
        nxt_s  = '0;
        if (!lst_g) begin
          nxt_g = g + GW'(1);
        end else begin
          nxt_g = '0;
          if (!lst_c) begin
            nxt_tc = tc + TCW'(1);
          end else begin
            nxt_tc = '0;
            nxt_tr = lst_r ? '0 : tr + TRW'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tr <= '0;
      tc <= '0;
      g  <= '0;
      s  <= '0;
      ph <= OP_LD_IN;
    end else if (adv) begin
      tr <= nxt_tr;
      tc <= nxt_tc;
      g  <= nxt_g;
      s  <= nxt_s;
      ph <= nxt_ph;
    end
  end
endmodule

// File: rtl/tile_sched_fmt.sv
module tile_sched_fmt
  import tile_sched_pkg::*;
#(
  parameter int TILE_H = 4,
  parameter int TILE_W = 4,
  parameter int TROWS  = 2,
  parameter int TCOLS  = 3,
  parameter int NGRP   = 2,
  parameter int NSLC   = 3,
  parameter int RW     = 5,
  parameter int CW     = 6,
  localparam int TRW = idx_w(TROWS),
  localparam int TCW = idx_w(TCOLS),
  localparam int GW  = idx_w(NGRP),
  localparam int SW  = idx_w(NSLC),
  localparam int WIW = idx_w(NGRP * NSLC)
) (
  input  logic [TRW-1:0] tr,
  input  logic [TCW-1:0] tc,
  input  logic [GW-1:0]  g,
  input  logic [SW-1:0]  s,
  output logic [RW-1:0]  org_r,
  output logic [CW-1:0]  org_c,
  output logic [RW-1:0]  win_r,
  output logic [CW-1:0]  win_c,
  output logic [3:0]     pad,
  output logic           first,
  output logic           last,
  output logic [WIW-1:0] wt_idx
);
  assign org_r  = RW'(int'(tr) * TILE_H);
  assign org_c  = CW'(int'(tc) * TILE_W);
  assign win_r  = org_r - RW'(1);
  assign win_c  = org_c - CW'(1);
  assign pad    = {tr == '0, tr == TRW'(TROWS - 1), tc == '0, tc == TCW'(TCOLS - 1)};
  assign wt_idx = WIW'(int'(g) * NSLC + int'(s));

  generate
    if (NSLC == 1) begin : g_single
      assign first = 1'b1;
      assign last  = 1'b1;
    end else begin : g_multi
      assign first = (s == '0);
      assign last  = (s == SW'(NSLC - 1));
    end
  endgenerate
endmodule

// File: rtl/tile_sched_top.sv
module tile_sched_top
  import tile_sched_pkg::*;
#(
  parameter int IMG_H    = 8,
  parameter int IMG_W    = 12,
  parameter int TILE_H   = 4,
  parameter int TILE_W   = 4,
  parameter int N_GROUPS = 2,
  parameter int N_SLICES = 3,
  localparam int TROWS = IMG_H / TILE_H,
  localparam int TCOLS = IMG_W / TILE_W,
  localparam int TRW = idx_w(TROWS),
  localparam int TCW = idx_w(TCOLS),
  localparam int GW  = idx_w(N_GROUPS),
  localparam int SW  = idx_w(N_SLICES),
  localparam int WIW = idx_w(N_GROUPS * N_SLICES),
  localparam int RW  = $clog2(IMG_H) + 2,
  localparam int CW  = $clog2(IMG_W) + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           done,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [1:0]     cmd_op,
  output logic [TRW-1:0] cmd_tile_r,
  output logic [TCW-1:0] cmd_tile_c,
  output logic [GW-1:0]  cmd_grp,
  output logic [SW-1:0]  cmd_slc,
  output logic [RW-1:0]  cmd_org_r,
  output logic [CW-1:0]  cmd_org_c,
  output logic [RW-1:0]  cmd_win_r,
  output logic [CW-1:0]  cmd_win_c,
  output logic [3:0]     cmd_pad,
  output logic           cmd_first,
  output logic           cmd_last,
  output logic [WIW-1:0] cmd_wt_idx
);
  logic running, hs, clear, adv, at_end;
  logic [TRW-1:0] n_tr, f_tr;
  logic [TCW-1:0] n_tc, f_tc;
  logic [GW-1:0]  n_g, f_g;
  logic [SW-1:0]  n_s, f_s;
  op_e            n_ph, f_ph;
  logic [RW-1:0]  f_org_r, f_win_r;
  logic [CW-1:0]  f_org_c, f_win_c;
  logic [3:0]     f_pad;
  logic           f_first, f_last;
  logic [WIW-1:0] f_wt;

  assign hs    = cmd_valid && cmd_ready;
  assign clear = !running && start;
  assign adv   = running && hs && !at_end;

  tile_sched_step #(
    .TROWS(TROWS), .TCOLS(TCOLS), .NGRP(N_GROUPS), .NSLC(N_SLICES)
  ) u_step (
    .clk(clk), .rst(rst), .clear(clear), .adv(adv),
    .nxt_tr(n_tr), .nxt_tc(n_tc), .nxt_g(n_g), .nxt_s(n_s), .nxt_ph(n_ph),
    .at_end(at_end)
  );

  assign f_tr = running ? n_tr : '0;
  assign f_tc = running ? n_tc : '0;
  assign f_g  = running ? n_g  : '0;
  assign f_s  = running ? n_s  : '0;
  assign f_ph = running ? n_ph : OP_LD_IN;

  tile_sched_fmt #(
    .TILE_H(TILE_H), .TILE_W(TILE_W), .TROWS(TROWS), .TCOLS(TCOLS),
    .NGRP(N_GROUPS), .NSLC(N_SLICES), .RW(RW), .CW(CW)
  ) u_fmt (
    .tr(f_tr), .tc(f_tc), .g(f_g), .s(f_s),
    .org_r(f_org_r), .org_c(f_org_c), .win_r(f_win_r), .win_c(f_win_c),
    .pad(f_pad), .first(f_first), .last(f_last), .wt_idx(f_wt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      cmd_valid  <= 1'b0;
      done       <= 1'b0;
      cmd_op     <= '0;
      cmd_tile_r <= '0;
      cmd_tile_c <= '0;
      cmd_grp    <= '0;
      cmd_slc    <= '0;
      cmd_org_r  <= '0;
      cmd_org_c  <= '0;
      cmd_win_r  <= '0;
      cmd_win_c  <= '0;
      cmd_pad    <= '0;
      cmd_first  <= 1'b0;
      cmd_last   <= 1'b0;
      cmd_wt_idx <= '0;
    end else begin
      done <= 1'b0;
      if (clear || adv) begin
        running    <= 1'b1;
        cmd_valid  <= 1'b1;
        cmd_op     <= f_ph;
        cmd_tile_r <= f_tr;
        cmd_tile_c <= f_tc;
        cmd_grp    <= f_g;
        cmd_slc    <= f_s;
        cmd_org_r  <= f_org_r;
        cmd_org_c  <= f_org_c;
        cmd_win_r  <= f_win_r;
        cmd_win_c  <= f_win_c;
        cmd_pad    <= f_pad;
        cmd_first  <= f_first;
        cmd_last   <= f_last;
        cmd_wt_idx <= f_wt;
      end else if (running && hs && at_end) begin
        running   <= 1'b0;
        cmd_valid <= 1'b0;
        done      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tile_sched_chk.sv
module tile_sched_chk #(
  parameter int TRW = 1,
  parameter int TCW = 2,
  parameter int GW  = 1,
  parameter int SW  = 2,
  parameter int RW  = 5,
  parameter int CW  = 6,
  parameter int WIW = 3,
  parameter int N_SLICES = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [1:0]     cmd_op,
  input logic [TRW-1:0] cmd_tile_r,
  input logic [TCW-1:0] cmd_tile_c,
  input logic [GW-1:0]  cmd_grp,
  input logic [SW-1:0]  cmd_slc,
  input logic [RW-1:0]  cmd_win_r,
  input logic [CW-1:0]  cmd_win_c,
  input logic           cmd_first,
  input logic           cmd_last,
  input logic [WIW-1:0] cmd_wt_idx
);
  // R2: stalled command holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_tile_r)
      && $stable(cmd_tile_c) && $stable(cmd_grp) && $stable(cmd_slc)
      && $stable(cmd_win_r) && $stable(cmd_win_c) && $stable(cmd_wt_idx)));

  // R5: a store only ever closes a group on its final slice
  a_r5_store_last: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |-> (cmd_last && cmd_slc == SW'(N_SLICES - 1)));

  // R4: first marker tracks the slice index
  a_r4_first: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_first == (cmd_slc == '0)));

  // R6: done is a single-cycle pulse that follows an accepted store
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cmd_valid && cmd_ready && cmd_op == 2'd3) && !cmd_valid));

  // R3: a non-store accepted command never moves to another tile
  a_r3_same_tile: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op != 2'd3) |=>
      (cmd_valid && $stable(cmd_tile_r) && $stable(cmd_tile_c) && $stable(cmd_grp)));
endmodule

bind tile_sched_top tile_sched_chk #(
  .TRW(TRW), .TCW(TCW), .GW(GW), .SW(SW), .RW(RW), .CW(CW), .WIW(WIW),
  .N_SLICES(N_SLICES)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_tile_r(cmd_tile_r), .cmd_tile_c(cmd_tile_c), .cmd_grp(cmd_grp),
  .cmd_slc(cmd_slc), .cmd_win_r(cmd_win_r), .cmd_win_c(cmd_win_c),
  .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_wt_idx(cmd_wt_idx)
);

// File: tb/sim_tile_sched_top.sv
`timescale 1ns/1ps
module sim_tile_sched_top;
  import tile_sched_pkg::*;
  localparam int IMG_H = 8, IMG_W = 12, TILE_H = 4, TILE_W = 4, NG = 2, NS = 3;
  localparam int TROWS = IMG_H / TILE_H, TCOLS = IMG_W / TILE_W;
  localparam int TRW = idx_w(TROWS), TCW = idx_w(TCOLS), GW = idx_w(NG), SW = idx_w(NS);
  localparam int WIW = idx_w(NG * NS);
  localparam int RW = $clog2(IMG_H) + 2, CW = $clog2(IMG_W) + 2;
  localparam int TOTAL = TROWS * TCOLS * NG * (3 * NS + 1);

  // each entry: {ready pattern, cycle at which a stray start is pulsed (0 = none)}
  localparam logic [15:0] RUNS [4] = '{16'hFF00, 16'hA500, 16'h1107, 16'h6C28};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cmd_ready = 1'b0;
  logic done, cmd_valid, cmd_first, cmd_last;
  logic [1:0] cmd_op;
  logic [TRW-1:0] cmd_tile_r;
  logic [TCW-1:0] cmd_tile_c;
  logic [GW-1:0] cmd_grp;
  logic [SW-1:0] cmd_slc;
  logic [RW-1:0] cmd_org_r, cmd_win_r;
  logic [CW-1:0] cmd_org_c, cmd_win_c;
  logic [3:0] cmd_pad;
  logic [WIW-1:0] cmd_wt_idx;

  int checks = 0, fails = 0, cyc = 0, issued = 0;
  logic [7:0] pat;
  logic [7:0] kick;

  always #2 clk = ~clk;

  tile_sched_top #(.IMG_H(IMG_H), .IMG_W(IMG_W), .TILE_H(TILE_H), .TILE_W(TILE_W),
                   .N_GROUPS(NG), .N_SLICES(NS)) u0 (
    .clk(clk), .rst(rst), .start(start), .done(done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_tile_r(cmd_tile_r), .cmd_tile_c(cmd_tile_c),
    .cmd_grp(cmd_grp), .cmd_slc(cmd_slc), .cmd_org_r(cmd_org_r), .cmd_org_c(cmd_org_c),
    .cmd_win_r(cmd_win_r), .cmd_win_c(cmd_win_c), .cmd_pad(cmd_pad),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_wt_idx(cmd_wt_idx));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected command built from the requirements (R3, R4, R5, R7, R8, R10, R11)
  function automatic logic [127:0] model(input int op, input int tr, input int tc,
                                         input int g, input int s);
    logic [RW-1:0] orr, wr;
    logic [CW-1:0] occ, wc;
    logic [3:0] pd;
    orr = RW'(tr * TILE_H);
    occ = CW'(tc * TILE_W);
    wr  = RW'(tr * TILE_H - 1);
    wc  = CW'(tc * TILE_W - 1);
    pd  = {tr == 0, tr == TROWS - 1, tc == 0, tc == TCOLS - 1};
    return 128'({2'(op), TRW'(tr), TCW'(tc), GW'(g), SW'(s), orr, occ, wr, wc, pd,
                 s == 0, s == NS - 1, WIW'(g * NS + s)});
  endfunction

  function automatic logic [127:0] actual();
    return 128'({cmd_op, cmd_tile_r, cmd_tile_c, cmd_grp, cmd_slc, cmd_org_r, cmd_org_c,
                 cmd_win_r, cmd_win_c, cmd_pad, cmd_first, cmd_last, cmd_wt_idx});
  endfunction

  task automatic expect_cmd(input int op, input int tr, input int tc, input int g, input int s);
    int wait_n = 0;
    while (1) begin
      @(negedge clk);
      cmd_ready = pat[cyc % 8];
      start = (kick != 0) && (cyc == int'(kick));
      cyc++;
      #1;
      if (cmd_valid) begin
        chk("R3/R2 command fields", actual(), model(op, tr, tc, g, s));
        if (cmd_ready) break;
      end
      wait_n++;
      if (wait_n > 100) begin
        chk("R3 command appears", 128'(cmd_valid), 128'(1));
        break;
      end
    end
    issued++;
  endtask

  task automatic run_layer();
    cyc = 0;
    issued = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int tr = 0; tr < TROWS; tr++)
      for (int tc = 0; tc < TCOLS; tc++)
        for (int g = 0; g < NG; g++) begin
          for (int s = 0; s < NS; s++) begin
            expect_cmd(0, tr, tc, g, s);   // R11 load-input
            expect_cmd(1, tr, tc, g, s);   // load-weight
            expect_cmd(2, tr, tc, g, s);   // compute
          end
          expect_cmd(3, tr, tc, g, NS - 1); // R5 store
        end
    @(negedge clk);
    cmd_ready = 1'b0;
    start = 1'b0;
    #1;
    chk("R6 done after final store", 128'({done, cmd_valid}), 128'(2'b10));
    chk("R12 command count", 128'(issued), 128'(TOTAL));
    @(negedge clk);
    #1;
    chk("R6 done single cycle", 128'({done, cmd_valid}), 128'(2'b00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", 128'({cmd_valid, done}), 128'(0));
    rst = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk("R1 idle without start", 128'({cmd_valid, done}), 128'(0));

    // main table: each run also re-launches after the previous done (R9)
    for (int i = 0; i < 4; i++) begin
      pat  = RUNS[i][15:8];
      kick = RUNS[i][7:0];
      run_layer();
    end

    // R2 directed: long stall on the first command
    pat = 8'h00;
    kick = 8'h00;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk("R2 stall hold first command", actual() | 128'(cmd_valid) << 100,
        model(0, 0, 0, 0, 0) | 128'(1) << 100);

    // R9: start during the stall does nothing
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R9 start ignored while busy", actual(), model(0, 0, 0, 0, 0));

    // R1: reset mid-layer clears the stream
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset mid-layer", 128'({cmd_valid, done}), 128'(0));
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule